// File: doc/BRIEF.md
# Multi-Port Counting Semaphore Unit

This block keeps a bank of counting semaphores that several agents use to hand buffers to each other. Six request ports reach it. Ports 0 to 3 carry processor traffic from the four neighbouring directions, port 4 serves the local DMA engine and port 5 serves a memory-mapped master. Each lock is a small unsigned counter and has no owner or "taken" flag, so a producer releases credits and a consumer acquires them.

Every request names a lock, an operation and an amount. The unit evaluates all valid requests in one cycle and returns a pass or fail flag per port on the next cycle. A failed request leaves the counter as it was, so the agent may simply try again. Requests that hit the same lock in one cycle are resolved one after another in port-index order, and each one sees the count left by the ports ahead of it. A separate initialisation path lets software write any counter directly and read any counter back.

Top module: `sem_lock_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every counter becomes 0 and `rsp_valid` and `rsp_ok` become 0.
- R2: A release (op code 0) adds the amount to the addressed counter and reports success when the sum fits in the counter.
- R3: An acquire-at-least (op code 1) succeeds only when the counter is greater than or equal to the amount, and on success it subtracts the amount; on failure the counter keeps its value.
- R4: An acquire-exact (op code 2) succeeds only when the counter equals the amount, and on success it leaves the counter at 0; on failure the counter keeps its value.
- R5: A release whose sum would exceed the counter maximum (63 for 6 bits) fails and leaves the counter unchanged.
- R6: Requests to one lock in the same cycle are applied in rising port-index order, with port 0 first. Each request is judged against the value that the lower-indexed ports left.
- R7: `rsp_valid[p]` equals `req_valid[p]` delayed by one clock, and `rsp_ok[p]` is never 1 while `rsp_valid[p]` is 0. Port p places its lock id at `req_lock[p*4 +: 4]`, its op at `req_op[p*2 +: 2]` and its amount at `req_amt[p*6 +: 6]`. Op code 3 is reserved and always fails without changing any counter.
- R8: A counter that receives no valid request and no initialisation write in a cycle keeps its value. Requests to different locks in the same cycle do not affect one another.
- R9: `init_wr_en` sets the counter `init_wr_id` to `init_wr_val` at the clock edge. The written value is applied before any request to that lock in the same cycle. `init_rd_val` shows the current value of counter `init_rd_id` without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 6 | Request strobe, one bit per port |
| req_lock | input | 24 | Lock id per port, 4 bits each |
| req_op | input | 12 | Operation per port, 2 bits each |
| req_amt | input | 36 | Amount per port, 6 bits each |
| rsp_valid | output | 6 | Response strobe, one cycle after the request |
| rsp_ok | output | 6 | Pass (1) or fail (0) per port |
| init_wr_en | input | 1 | Direct counter write enable |
| init_wr_id | input | 4 | Counter written directly |
| init_wr_val | input | 6 | Value written directly |
| init_rd_id | input | 4 | Counter read directly |
| init_rd_val | output | 6 | Current value of the read counter |

## Verification
The bound checker checks several rules on every cycle. It confirms that untouched counters hold their value, that an initialisation write without competing requests lands exactly, that a sole acquire short of credits or a sole overflowing release is refused, that no pass appears without a response strobe, and that reset clears the bank. The in-order resolution of several ports on one lock, the exact-match acquire and the combined effect of a write and a request in the same cycle are shown by the bench only. The bench compares every response and a rotating counter readback against its behavioural model, first in directed scenarios and then under random traffic that is crowded onto a few locks.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int DEF_LOCKS = 16;
    localparam int DEF_CNT_W = 6;
    localparam int DEF_PORTS = 6;
    localparam int OP_W      = 2;

    typedef enum logic [OP_W-1:0] {
        OP_RELEASE = 2'd0,
        OP_ACQ_GE  = 2'd1,
        OP_ACQ_EQ  = 2'd2,
        OP_RSVD    = 2'd3
    } sem_op_e;

    function automatic logic op_is_acquire(input sem_op_e op);
        return (op == OP_ACQ_GE) || (op == OP_ACQ_EQ);
    endfunction

endpackage

// File: rtl/sem_lock_slice.sv
// Resolves all same-cycle requests that target one counter, in port order.
module sem_lock_slice
    import sem_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_PORTS = DEF_PORTS,
    parameter int LID_W     = 4,
    parameter int LOCK_IDX  = 0
) (
    input  logic [CNT_W-1:0]           cur,
    input  logic                       wr_hit,
    input  logic [CNT_W-1:0]           wr_val,
    input  logic [NUM_PORTS-1:0]       req_valid,
    input  logic [NUM_PORTS*LID_W-1:0] req_lock,
    input  logic [NUM_PORTS*OP_W-1:0]  req_op,
    input  logic [NUM_PORTS*CNT_W-1:0] req_amt,
    output logic [CNT_W-1:0]           nxt,
    output logic [NUM_PORTS-1:0]       ok_mask
);

    logic [CNT_W-1:0] run_val;
    logic [CNT_W-1:0] amt;
    logic [CNT_W:0]   sum;
    sem_op_e          op;

    always_comb begin
        run_val = wr_hit ? wr_val : cur;
        ok_mask = '0;
        amt     = '0;
        sum     = '0;
        op      = OP_RSVD;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_valid[p] && (req_lock[p*LID_W +: LID_W] == LID_W'(LOCK_IDX))) begin
                amt = req_amt[p*CNT_W +: CNT_W];
                op  = sem_op_e'(req_op[p*OP_W +: OP_W]);
                sum = {1'b0, run_val} + {1'b0, amt};
                case (op)
                    OP_RELEASE: begin
                        if (!sum[CNT_W]) begin
                            ok_mask[p] = 1'b1;
                            run_val    = sum[CNT_W-1:0];
                        end
                    end
                    OP_ACQ_GE: begin
                        if (run_val >= amt) begin
                            ok_mask[p] = 1'b1;
                            run_val    = run_val - amt;
                        end
                    end
                    OP_ACQ_EQ: begin
                        if (run_val == amt) begin
                            ok_mask[p] = 1'b1;
                            run_val    = '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
        nxt = run_val;
    end

endmodule

// File: rtl/sem_resp_stage.sv
// Collapses per-lock pass masks into one flag per port and registers them.
module sem_resp_stage #(
    parameter int NUM_LOCKS = 16,
    parameter int NUM_PORTS = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_PORTS-1:0]                req_valid,
    input  logic [NUM_LOCKS-1:0][NUM_PORTS-1:0] ok_mat,
    output logic [NUM_PORTS-1:0]                rsp_valid,
    output logic [NUM_PORTS-1:0]                rsp_ok
);

    logic [NUM_PORTS-1:0] ok_any;

    always_comb begin
        ok_any = '0;
        for (int l = 0; l < NUM_LOCKS; l++) begin
            ok_any = ok_any | ok_mat[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= '0;
            rsp_ok    <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= ok_any & req_valid;
        end
    end

endmodule

// File: rtl/sem_lock_unit.sv
module sem_lock_unit
    import sem_pkg::*;
#(
    parameter int NUM_LOCKS = DEF_LOCKS,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_PORTS = DEF_PORTS,
    localparam int LID_W    = $clog2(NUM_LOCKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PORTS-1:0]       req_valid,
    input  logic [NUM_PORTS*LID_W-1:0] req_lock,
    input  logic [NUM_PORTS*OP_W-1:0]  req_op,
    input  logic [NUM_PORTS*CNT_W-1:0] req_amt,
    output logic [NUM_PORTS-1:0]       rsp_valid,
    output logic [NUM_PORTS-1:0]       rsp_ok,
    input  logic                       init_wr_en,
    input  logic [LID_W-1:0]           init_wr_id,
    input  logic [CNT_W-1:0]           init_wr_val,
    input  logic [LID_W-1:0]           init_rd_id,
    output logic [CNT_W-1:0]           init_rd_val
);

    logic [NUM_LOCKS-1:0][CNT_W-1:0]     lock_q;
    logic [NUM_LOCKS-1:0][CNT_W-1:0]     lock_d;
    logic [NUM_LOCKS-1:0][NUM_PORTS-1:0] ok_mat;

    for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
        logic wr_hit;
        assign wr_hit = init_wr_en && (init_wr_id == LID_W'(l));

        sem_lock_slice #(
            .CNT_W     (CNT_W),
            .NUM_PORTS (NUM_PORTS),
            .LID_W     (LID_W),
            .LOCK_IDX  (l)
        ) u_slice (
            .cur       (lock_q[l]),
            .wr_hit    (wr_hit),
            .wr_val    (init_wr_val),
            .req_valid (req_valid),
            .req_lock  (req_lock),
            .req_op    (req_op),
            .req_amt   (req_amt),
            .nxt       (lock_d[l]),
            .ok_mask   (ok_mat[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) lock_q <= '0;
        else     lock_q <= lock_d;
    end

    assign init_rd_val = lock_q[init_rd_id];

    sem_resp_stage #(
        .NUM_LOCKS (NUM_LOCKS),
        .NUM_PORTS (NUM_PORTS)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ok_mat    (ok_mat),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok)
    );

endmodule

// File: rtl/sem_lock_chk.sv
module sem_lock_chk
    import sem_pkg::*;
#(
    parameter int NUM_LOCKS = DEF_LOCKS,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_PORTS = DEF_PORTS,
    parameter int LID_W     = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_PORTS-1:0]            req_valid,
    input logic [NUM_PORTS*LID_W-1:0]      req_lock,
    input logic [NUM_PORTS*OP_W-1:0]       req_op,
    input logic [NUM_PORTS*CNT_W-1:0]      req_amt,
    input logic [NUM_PORTS-1:0]            rsp_valid,
    input logic [NUM_PORTS-1:0]            rsp_ok,
    input logic                            init_wr_en,
    input logic [LID_W-1:0]                init_wr_id,
    input logic [CNT_W-1:0]                init_wr_val,
    input logic [NUM_LOCKS-1:0][CNT_W-1:0] lock_q
);

    logic [NUM_LOCKS-1:0]            lock_req;
    logic [NUM_LOCKS-1:0]            lock_wr;
    logic [NUM_PORTS-1:0]            solo;
    logic [NUM_PORTS-1:0][CNT_W-1:0] cur_p;
    logic [NUM_PORTS-1:0][CNT_W:0]   sum_p;

    always_comb begin
        lock_req = '0;
        lock_wr  = '0;
        for (int l = 0; l < NUM_LOCKS; l++) begin
            lock_wr[l] = init_wr_en && (init_wr_id == LID_W'(l));
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (req_valid[p] && (req_lock[p*LID_W +: LID_W] == LID_W'(l)))
                    lock_req[l] = 1'b1;
            end
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            cur_p[p] = lock_q[req_lock[p*LID_W +: LID_W]];
            sum_p[p] = {1'b0, cur_p[p]} + {1'b0, req_amt[p*CNT_W +: CNT_W]};
            solo[p]  = req_valid[p] &&
                       !(init_wr_en && (init_wr_id == req_lock[p*LID_W +: LID_W]));
            for (int q = 0; q < NUM_PORTS; q++) begin
                if (q != p && req_valid[q] &&
                    (req_lock[q*LID_W +: LID_W] == req_lock[p*LID_W +: LID_W]))
                    solo[p] = 1'b0;
            end
        end
    end

    // R1: reset clears every counter
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (lock_q == '0));

    for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lk
        // R8: an untouched counter holds
        a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
            (!lock_req[l] && !lock_wr[l]) |=> $stable(lock_q[l]));
        // R9: a lone direct write lands exactly
        a_r9_init_write: assert property (@(posedge clk) disable iff (rst)
            (lock_wr[l] && !lock_req[l]) |=> (lock_q[l] == $past(init_wr_val)));
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pt
        // R3: a lone acquire short of credits is refused
        a_r3_acq_short_fails: assert property (@(posedge clk) disable iff (rst)
            (solo[p] && req_op[p*OP_W +: OP_W] == OP_ACQ_GE &&
             cur_p[p] < req_amt[p*CNT_W +: CNT_W]) |=> !rsp_ok[p]);
        // R5: a lone release that would overflow is refused
        a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
            (solo[p] && req_op[p*OP_W +: OP_W] == OP_RELEASE && sum_p[p][CNT_W])
            |=> !rsp_ok[p]);
        // R7: a pass always comes with a response strobe
        a_r7_ok_needs_valid: assert property (@(posedge clk) disable iff (rst)
            rsp_ok[p] |-> rsp_valid[p]);
    end

endmodule

bind sem_lock_unit sem_lock_chk #(
    .NUM_LOCKS (NUM_LOCKS),
    .CNT_W     (CNT_W),
    .NUM_PORTS (NUM_PORTS),
    .LID_W     (LID_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_lock    (req_lock),
    .req_op      (req_op),
    .req_amt     (req_amt),
    .rsp_valid   (rsp_valid),
    .rsp_ok      (rsp_ok),
    .init_wr_en  (init_wr_en),
    .init_wr_id  (init_wr_id),
    .init_wr_val (init_wr_val),
    .lock_q      (lock_q)
);

// File: tb/tb_sem_lock_unit.sv
module tb_sem_lock_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int NP = 6;
    localparam int CW = 6;
    localparam int LW = 4;
    localparam int MAXV = 63;

    logic            clk = 1'b0;
    logic            rst;
    logic [NP-1:0]   req_valid;
    logic [NP*LW-1:0] req_lock;
    logic [NP*2-1:0] req_op;
    logic [NP*CW-1:0] req_amt;
    logic [NP-1:0]   rsp_valid;
    logic [NP-1:0]   rsp_ok;
    logic            init_wr_en;
    logic [LW-1:0]   init_wr_id;
    logic [CW-1:0]   init_wr_val;
    logic [LW-1:0]   init_rd_id;
    logic [CW-1:0]   init_rd_val;

    bit [NP-1:0] b_valid;
    int b_lock[NP];
    int b_op[NP];
    int b_amt[NP];
    bit b_wr;
    int b_wr_id, b_wr_val, b_rd;

    int mdl[NL];
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        req_valid = b_valid;
        for (int p = 0; p < NP; p++) begin
            req_lock[p*LW +: LW] = LW'(b_lock[p]);
            req_op[p*2 +: 2]     = 2'(b_op[p]);
            req_amt[p*CW +: CW]  = CW'(b_amt[p]);
        end
        init_wr_en  = b_wr;
        init_wr_id  = LW'(b_wr_id);
        init_wr_val = CW'(b_wr_val);
        init_rd_id  = LW'(b_rd);
    end

    sem_lock_unit dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_lock(req_lock), .req_op(req_op), .req_amt(req_amt),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .init_wr_en(init_wr_en), .init_wr_id(init_wr_id), .init_wr_val(init_wr_val),
        .init_rd_id(init_rd_id), .init_rd_val(init_rd_val)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        b_valid = '0;
        for (int p = 0; p < NP; p++) begin
            b_lock[p] = 0; b_op[p] = 0; b_amt[p] = 0;
        end
        b_wr = 0; b_wr_id = 0; b_wr_val = 0;
    endtask

    task automatic set_req(input int p, input int lk, input int op, input int amt);
        b_valid[p] = 1'b1; b_lock[p] = lk; b_op[p] = op; b_amt[p] = amt;
    endtask

    // One clock: model update, then response and readback comparison.
    task automatic run_cycle();
        bit    exp_ok[NP];
        string tag[NP];
        bit    seen[NL];
        int    cur, l;
        for (int i = 0; i < NL; i++) seen[i] = 0;
        if (b_wr) mdl[b_wr_id] = b_wr_val;               // R9 write comes first
        for (int p = 0; p < NP; p++) begin
            exp_ok[p] = 0;
            tag[p] = "R7";
            if (b_valid[p]) begin
                l = b_lock[p];
                cur = mdl[l];
                case (b_op[p])
                    0: begin
                        tag[p] = (cur + b_amt[p] > MAXV) ? "R5" : "R2";
                        if (cur + b_amt[p] <= MAXV) begin exp_ok[p] = 1; mdl[l] = cur + b_amt[p]; end
                    end
                    1: begin
                        tag[p] = "R3";
                        if (cur >= b_amt[p]) begin exp_ok[p] = 1; mdl[l] = cur - b_amt[p]; end
                    end
                    2: begin
                        tag[p] = "R4";
                        if (cur == b_amt[p]) begin exp_ok[p] = 1; mdl[l] = 0; end
                    end
                    default: tag[p] = "R7";
                endcase
                if (seen[l]) tag[p] = "R6";
                seen[l] = 1;
            end
        end
        @(posedge clk);
        #1;
        for (int p = 0; p < NP; p++) begin
            chk(rsp_valid[p] === b_valid[p], "R7 rsp_valid", int'(rsp_valid[p]), int'(b_valid[p]));
            chk(rsp_ok[p] === exp_ok[p], tag[p], int'(rsp_ok[p]), int'(exp_ok[p]));
        end
        chk(init_rd_val === CW'(mdl[b_rd]), "R9 readback", int'(init_rd_val), mdl[b_rd]);
        @(negedge clk);
    endtask

    task automatic read_lock(input int lk, input string req);
        b_rd = lk;
        #1;
        chk(init_rd_val === CW'(mdl[lk]), req, int'(init_rd_val), mdl[lk]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) mdl[i] = 0;
        clr();
        b_rd = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(rsp_valid === '0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(rsp_ok === '0, "R1 rsp_ok", int'(rsp_ok), 0);
        for (int l = 0; l < NL; l++) read_lock(l, "R1 counter");

        // R2: release
        clr(); b_rd = 3; set_req(0, 3, 0, 5); run_cycle();
        // R3: acquire-at-least short then exact fit
        clr(); set_req(1, 3, 1, 6); run_cycle();
        chk(init_rd_val === 6'd5, "R3 unchanged", int'(init_rd_val), 5);
        clr(); set_req(4, 3, 1, 5); run_cycle();
        chk(init_rd_val === 6'd0, "R3 drained", int'(init_rd_val), 0);
        // R4: acquire-exact
        clr(); b_rd = 9; set_req(5, 9, 0, 4); run_cycle();
        clr(); set_req(2, 9, 2, 3); run_cycle();
        clr(); set_req(2, 9, 2, 4); run_cycle();
        chk(init_rd_val === 6'd0, "R4 zeroed", int'(init_rd_val), 0);
        // R5: release overflow near the top
        clr(); b_rd = 2; b_wr = 1; b_wr_id = 2; b_wr_val = 60; run_cycle();
        clr(); set_req(3, 2, 0, 4); run_cycle();
        chk(init_rd_val === 6'd60, "R5 unchanged", int'(init_rd_val), 60);
        clr(); set_req(3, 2, 0, 3); run_cycle();
        chk(init_rd_val === 6'd63, "R5 at max", int'(init_rd_val), 63);
        // R6: six ports on one lock in one cycle
        clr(); b_rd = 7; b_wr = 1; b_wr_id = 7; b_wr_val = 2; run_cycle();
        clr();
        set_req(0, 7, 1, 2); set_req(1, 7, 1, 1); set_req(2, 7, 0, 3);
        set_req(3, 7, 2, 3); set_req(4, 7, 0, 63); set_req(5, 7, 0, 1);
        run_cycle();
        chk(rsp_ok === 6'b011101, "R6 pass pattern", int'(rsp_ok), 'b011101);
        chk(init_rd_val === 6'd63, "R6 final", int'(init_rd_val), 63);
        // R8: independent locks in one cycle
        clr(); b_rd = 12;
        for (int p = 0; p < NP; p++) set_req(p, 10 + p, 0, p + 1);
        run_cycle();
        read_lock(7, "R8 untouched");
        read_lock(15, "R8 port5 lock");
        // R9: write and request on the same lock in one cycle
        clr(); b_rd = 11; b_wr = 1; b_wr_id = 11; b_wr_val = 10; set_req(0, 11, 1, 10); run_cycle();
        chk(init_rd_val === 6'd0, "R9 write then acquire", int'(init_rd_val), 0);
        // R7: reserved op
        clr(); b_rd = 2; set_req(1, 2, 3, 1); run_cycle();
        chk(init_rd_val === 6'd63, "R7 reserved no change", int'(init_rd_val), 63);

        // Random traffic crowded onto four locks
        for (int c = 0; c < 3000; c++) begin
            clr();
            b_rd = c % 4;
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(0, 2) != 0)
                    set_req(p, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 40));
            end
            if ($urandom_range(0, 15) == 0) begin
                b_wr = 1; b_wr_id = $urandom_range(0, 4); b_wr_val = $urandom_range(0, 63);
            end
            run_cycle();
        end
        clr();
        for (int l = 0; l < NL; l++) read_lock(l, "R8 final sweep");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule